// File: doc/BRIEF.md
# Reverse-Polish Stack Expression Evaluator

This block evaluates integer arithmetic written in postfix order. A producer hands it one token at a time over a valid/ready handshake. A token either pushes a 16-bit operand onto an internal evaluation stack or applies an operator. An operator takes the two topmost entries, combines them, and puts the single result back in their place. A terminating token then delivers the one value that remains as the result of the expression.

The stack holds a fixed number of entries. The block watches every token for misuse: a push into a full stack, an operator that lacks two operands, a division by zero, or a terminating token that does not find exactly one entry. Each of these raises a one-cycle error pulse that carries a code. After the first three kinds, the evaluator discards the rest of the broken expression up to its terminating token. It then starts clean on the next expression.

Top module: `rpn_eval`

## Requirements
- R1: After a synchronous active-low reset, the stack is empty, `tok_ready` is high, and neither `res_valid` nor `err_valid` is asserted.
- R2: `tok_kind` encodes 0 = push `tok_data`, 1 = add, 2 = subtract, 3 = multiply, 4 = divide, 5 = end of expression. Kinds 6 and 7 are accepted and leave the stack unchanged.
- R3: Add and multiply replace the two topmost entries with their sum or product. The stream a b c * + a d c * + e - / yields (a + b*c) / (a + d*c - e).
- R4: For subtract and divide, the entry second from the top is the left operand and the topmost entry is the right operand.
- R5: An end token that finds exactly one entry raises `res_valid` for one cycle, in the cycle after the token is accepted. That cycle carries the entry on `res_data` and leaves the stack empty.
- R6: An end token that finds zero entries or two or more entries raises `err_valid` with `err_code` 4 (malformed). It also empties the stack and produces no result.
- R7: After an operator is accepted, `tok_ready` is low for exactly the next cycle and then returns high.
- R8: Arithmetic is 16-bit two's complement. Results wrap modulo 2^16, and division truncates toward zero.
- R9: A push accepted while the stack already holds DEPTH entries raises `err_code` 1 (overflow) and aborts the expression.
- R10: An operator accepted while fewer than two entries are present raises `err_code` 2 (underflow) and aborts the expression.
- R11: A divide whose right operand is zero raises `err_code` 3 one cycle after the low-ready cycle. Every later token up to and including the next end token is consumed with no effect. After an abort (R9 to R11), the next expression starts from an empty stack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_valid | input | 1 | Token present |
| tok_ready | output | 1 | Block can accept a token this cycle |
| tok_kind | input | 3 | Token kind (see R2) |
| tok_data | input | W | Operand value for a push |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | W | Result value, held until the next result |
| err_valid | output | 1 | One-cycle error strobe |
| err_code | output | 3 | Error kind: 1 overflow, 2 underflow, 3 divide by zero, 4 malformed |

## Verification
Some properties are checked by assertions on every cycle:
- the low-ready bubble never lasts longer than one cycle;
- a result or error pulse never coincides with another pulse;
- a result only follows an accepted end token and leaves the stack empty;
- the occupancy never exceeds the depth;
- each error code lines up with the token or execution cycle that caused it.

Only the bench's scenarios can show the rest. These cover the operand order, wrapping and truncation of the arithmetic, the full worked expression, and that tokens after an abort are really discarded. The bench compares every output against a queue-based model on every clock.

// File: rtl/rpn_pkg.sv
// Shared encodings for the postfix evaluator: token kinds, error codes
// and controller states. Assumes a 3-bit token kind field.
package rpn_pkg;

    typedef enum logic [2:0] {
        TK_PUSH = 3'd0,
        TK_ADD  = 3'd1,
        TK_SUB  = 3'd2,
        TK_MUL  = 3'd3,
        TK_DIV  = 3'd4,
        TK_END  = 3'd5
    } tok_kind_e;

    typedef enum logic [2:0] {
        EC_NONE      = 3'd0,
        EC_OVERFLOW  = 3'd1,
        EC_UNDERFLOW = 3'd2,
        EC_DIVZERO   = 3'd3,
        EC_MALFORMED = 3'd4
    } err_code_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_EXEC  = 2'd1,
        ST_DRAIN = 2'd2
    } ev_state_e;

endpackage

// File: rtl/rpn_alu.sv
// Combinational two-operand arithmetic for the evaluator.
// Assumes lhs is the entry below the top and rhs the top entry.
// Results wrap to W bits; division truncates toward zero, and the
// most-negative / -1 case wraps to the most-negative value.
module rpn_alu
    import rpn_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2:0]          op,
    input  logic signed [W-1:0] lhs,
    input  logic signed [W-1:0] rhs,
    output logic signed [W-1:0] result,
    output logic                div_zero
);

    localparam logic signed [W-1:0] MIN_VAL = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] NEG_ONE = '1;

    // Select the operation and flag a zero divisor.
    always_comb begin
        div_zero = (op == TK_DIV) && (rhs == '0);
        case (op)
            TK_ADD:  result = lhs + rhs;
            TK_SUB:  result = lhs - rhs;
            TK_MUL:  result = lhs * rhs;
            TK_DIV: begin
                if (div_zero)
                    result = '0;
                else if (lhs == MIN_VAL && rhs == NEG_ONE)
                    result = MIN_VAL;
                else
                    result = lhs / rhs;
            end
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/rpn_stack.sv
// Register-file evaluation stack with an occupancy counter.
// push writes wdata above the top; combine overwrites the second entry
// with wdata and drops the top; clear empties it. The caller guarantees
// push is never asserted when full and combine only with two or more entries.
module rpn_stack #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       push,
    input  logic                       combine,
    input  logic [W-1:0]               wdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic [W-1:0]               top,
    output logic [W-1:0]               below
);

    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0] slot [DEPTH];

    // Write the addressed entry on a push or a combine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if ((push && int'(count) == i) || (combine && int'(count) == i + 2))
                    slot[i] <= wdata;
            end
        end
    end

    // Track how many entries are live.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            count <= '0;
        else if (push)
            count <= count + CW'(1);
        else if (combine)
            count <= count - CW'(1);
    end

    // Read the two topmost entries.
    always_comb begin
        top   = '0;
        below = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(count) == i + 1) top   = slot[i];
            if (int'(count) == i + 2) below = slot[i];
        end
    end

endmodule

// File: rtl/rpn_eval.sv
// Postfix expression evaluator: accepts tokens over valid/ready, keeps
// operands on a finite stack, applies operators in a separate execute
// cycle (ready low), and reports a result or an error as one-cycle pulses.
// Assumes tok_kind/tok_data are stable while tok_valid waits for ready.
module rpn_eval
    import rpn_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tok_valid,
    output logic         tok_ready,
    input  logic [2:0]   tok_kind,
    input  logic [W-1:0] tok_data,
    output logic         res_valid,
    output logic [W-1:0] res_data,
    output logic         err_valid,
    output logic [2:0]   err_code
);

    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    ev_state_e     state, state_nx;
    logic [2:0]    op_q;
    logic [CW-1:0] stk_cnt;
    logic [W-1:0]  stk_top, stk_below, stk_wdata;
    logic [W-1:0]  alu_res;
    logic          alu_dz;
    logic          fire, do_push, do_combine, do_clear;
    logic          set_res, set_err;
    err_code_e     ecode;

    assign tok_ready = (state != ST_EXEC);
    assign fire      = tok_valid && tok_ready;
    assign stk_wdata = do_push ? tok_data : alu_res;

    rpn_stack #(.W(W), .DEPTH(DEPTH)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (do_clear),
        .push    (do_push),
        .combine (do_combine),
        .wdata   (stk_wdata),
        .count   (stk_cnt),
        .top     (stk_top),
        .below   (stk_below)
    );

    rpn_alu #(.W(W)) u_alu (
        .op       (op_q),
        .lhs      (stk_below),
        .rhs      (stk_top),
        .result   (alu_res),
        .div_zero (alu_dz)
    );

    // Decide stack action, next state and any pulse for this cycle.
    always_comb begin
        state_nx   = state;
        do_push    = 1'b0;
        do_combine = 1'b0;
        do_clear   = 1'b0;
        set_res    = 1'b0;
        set_err    = 1'b0;
        ecode      = EC_NONE;
        case (state)
            ST_RUN: begin
                if (fire) begin
                    case (tok_kind)
                        TK_PUSH: begin
                            if (stk_cnt == FULL) begin
                                set_err  = 1'b1;
                                ecode    = EC_OVERFLOW;
                                do_clear = 1'b1;
                                state_nx = ST_DRAIN;
                            end else begin
                                do_push = 1'b1;
                            end
                        end
                        TK_ADD, TK_SUB, TK_MUL, TK_DIV: begin
                            if (stk_cnt < CW'(2)) begin
                                set_err  = 1'b1;
                                ecode    = EC_UNDERFLOW;
                                do_clear = 1'b1;
                                state_nx = ST_DRAIN;
                            end else begin
                                state_nx = ST_EXEC;
                            end
                        end
                        TK_END: begin
                            do_clear = 1'b1;
                            if (stk_cnt == CW'(1)) begin
                                set_res = 1'b1;
                            end else begin
                                set_err = 1'b1;
                                ecode   = EC_MALFORMED;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_EXEC: begin
                if (alu_dz) begin
                    set_err  = 1'b1;
                    ecode    = EC_DIVZERO;
                    do_clear = 1'b1;
                    state_nx = ST_DRAIN;
                end else begin
                    do_combine = 1'b1;
                    state_nx   = ST_RUN;
                end
            end
            ST_DRAIN: begin
                if (fire && tok_kind == TK_END) state_nx = ST_RUN;
            end
            default: state_nx = ST_RUN;
        endcase
    end

    // Advance the controller and latch the operator for the execute cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
            op_q  <= '0;
        end else begin
            state <= state_nx;
            if (fire && state == ST_RUN) op_q <= tok_kind;
        end
    end

    // Register the result and error pulses with their data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            err_valid <= 1'b0;
            err_code  <= EC_NONE;
        end else begin
            res_valid <= set_res;
            err_valid <= set_err;
            if (set_res) res_data <= stk_top;
            if (set_err) err_code <= ecode;
        end
    end

endmodule

// File: rtl/rpn_eval_chk.sv
// Assertion checker for the postfix evaluator, bound to every instance.
// Observes the token handshake, pulses and the stack occupancy.
module rpn_eval_chk
    import rpn_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tok_valid,
    input logic                       tok_ready,
    input logic [2:0]                 tok_kind,
    input logic                       res_valid,
    input logic                       err_valid,
    input logic [2:0]                 err_code,
    input logic [$clog2(DEPTH+1)-1:0] stk_cnt
);

    logic acc_op;
    assign acc_op = tok_valid && tok_ready && tok_kind >= 3'd1 && tok_kind <= 3'd4;

    AST_READY_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_ready |=> tok_ready); // R7

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && err_valid)); // R5

    AST_RES_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(tok_valid && tok_ready && tok_kind == TK_END)); // R5

    AST_RES_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> stk_cnt == '0); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(stk_cnt) <= DEPTH); // R9

    AST_UNDERFLOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_code == EC_UNDERFLOW) |-> $past(acc_op)); // R10

    AST_DIVZERO_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_code == EC_DIVZERO) |-> $past(!tok_ready)); // R11

    AST_ERR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> stk_cnt == '0); // R6

endmodule

bind rpn_eval rpn_eval_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_valid (tok_valid),
    .tok_ready (tok_ready),
    .tok_kind  (tok_kind),
    .res_valid (res_valid),
    .err_valid (err_valid),
    .err_code  (err_code),
    .stk_cnt   (stk_cnt)
);

// File: tb/rpn_eval_test.sv
// Self-checking bench: a queue-based reference model compared on every
// clock, plus scenario checks with hand-computed expected values.
module rpn_eval_test;

    localparam int W     = 16;
    localparam int DEPTH = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tv = 1'b0;
    logic [2:0]   tk = '0;
    logic [W-1:0] td = '0;
    logic         tok_ready, res_valid, err_valid;
    logic [W-1:0] res_data;
    logic [2:0]   err_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rpn_eval #(.W(W), .DEPTH(DEPTH)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_valid (tv),
        .tok_ready (tok_ready),
        .tok_kind  (tk),
        .tok_data  (td),
        .res_valid (res_valid),
        .res_data  (res_data),
        .err_valid (err_valid),
        .err_code  (err_code)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int   m_stk[$];
    int   m_mode = 0;
    int   m_op = 0;
    bit   e_rv = 0, e_ev = 0;
    int   e_rd = 0, e_ec = 0;

    function automatic int wrap16(input int x);
        return int'(shortint'(x));
    endfunction

    function automatic int apply(input int op, input int a, input int b);
        int r;
        case (op)
            1: r = a + b;
            2: r = a - b;
            3: r = a * b;
            default: r = (a == -32768 && b == -1) ? -32768 : a / b;
        endcase
        return wrap16(r);
    endfunction

    // Advance the model on each edge from the sampled inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_stk.delete();
            m_mode = 0;
            e_rv = 0; e_ev = 0; e_rd = 0; e_ec = 0;
        end else begin
            e_rv = 0; e_ev = 0;
            case (m_mode)
                1: begin
                    int a, b;
                    b = m_stk.pop_back();
                    a = m_stk.pop_back();
                    if (m_op == 4 && b == 0) begin
                        e_ev = 1; e_ec = 3; m_stk.delete(); m_mode = 2;
                    end else begin
                        m_stk.push_back(apply(m_op, a, b));
                        m_mode = 0;
                    end
                end
                2: if (tv && tk == 3'd5) m_mode = 0;
                default: if (tv) begin
                    if (tk == 3'd0) begin
                        if (m_stk.size() == DEPTH) begin
                            e_ev = 1; e_ec = 1; m_stk.delete(); m_mode = 2;
                        end else m_stk.push_back(int'($signed(td)));
                    end else if (tk >= 3'd1 && tk <= 3'd4) begin
                        if (m_stk.size() < 2) begin
                            e_ev = 1; e_ec = 2; m_stk.delete(); m_mode = 2;
                        end else begin
                            m_op = int'(tk); m_mode = 1;
                        end
                    end else if (tk == 3'd5) begin
                        if (m_stk.size() == 1) begin
                            e_rv = 1; e_rd = m_stk[0];
                        end else begin
                            e_ev = 1; e_ec = 4;
                        end
                        m_stk.delete();
                    end
                end
            endcase
        end
    end

    // Compare every output against the model away from the edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(tok_ready == (m_mode != 1), "R7", "tok_ready", tok_ready, m_mode != 1);
            chk(res_valid == e_rv, "R5", "res_valid", res_valid, e_rv);
            if (e_rv)
                chk(res_data == e_rd[15:0], "R8", "res_data",
                    int'($signed(res_data)), e_rd);
            chk(err_valid == e_ev, "R9", "err_valid", err_valid, e_ev);
            if (e_ev)
                chk(int'(err_code) == e_ec, "R11", "err_code", err_code, e_ec);
        end
    end

    // ---------------- scenario capture ----------------
    bit seen_res = 0, seen_err = 0;
    int last_res = 0, last_err = 0;

    always @(negedge clk) begin
        if (res_valid) begin seen_res = 1; last_res = int'($signed(res_data)); end
        if (err_valid) begin seen_err = 1; last_err = int'(err_code); end
    end

    task automatic send(input int kind, input int data);
        tv = 1'b1;
        tk = 3'(kind);
        td = 16'(data);
        while (!tok_ready) @(negedge clk);
        @(negedge clk);
        tv = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic clear_seen();
        seen_res = 0; seen_err = 0;
    endtask

    task automatic expect_res(input string req, input int exp);
        settle();
        chk(seen_res && !seen_err && last_res == exp, req, "result",
            seen_res ? last_res : -99999, exp);
        clear_seen();
    endtask

    task automatic expect_err(input string req, input int code);
        settle();
        chk(seen_err && !seen_res && last_err == code, req, "error code",
            seen_err ? last_err : -1, code);
        clear_seen();
    endtask

    localparam int P = 0, ADD = 1, SUB = 2, MUL = 3, DIV = 4, FIN = 5;

    initial begin
        int a, b, c, d, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: reset state
        chk(tok_ready == 1'b1, "R1", "tok_ready after reset", tok_ready, 1);
        chk(res_valid == 1'b0 && err_valid == 1'b0, "R1", "pulses after reset",
            res_valid | err_valid, 0);
        send(FIN, 0);
        expect_err("R1", 4);              // empty stack proves reset emptied it

        // R3: full worked expression
        a = 10; b = 6; c = 5; d = 2; e = 7;
        send(P, a); send(P, b); send(P, c); send(MUL, 0); send(ADD, 0);
        send(P, a); send(P, d); send(P, c); send(MUL, 0); send(ADD, 0);
        send(P, e); send(SUB, 0); send(DIV, 0); send(FIN, 0);
        expect_res("R3", (a + b * c) / (a + d * c - e));

        // R4: operand order for subtract and divide
        send(P, 3); send(P, 5); send(SUB, 0); send(FIN, 0);
        expect_res("R4", -2);
        send(P, 20); send(P, 4); send(DIV, 0); send(FIN, 0);
        expect_res("R4", 5);

        // R8: wrap and truncation toward zero
        send(P, 200); send(P, 200); send(MUL, 0); send(FIN, 0);
        expect_res("R8", 40000 - 65536);
        send(P, -7); send(P, 2); send(DIV, 0); send(FIN, 0);
        expect_res("R8", -3);
        send(P, 32767); send(P, 1); send(ADD, 0); send(FIN, 0);
        expect_res("R8", -32768);

        // R7: one-cycle ready bubble after an operator
        send(P, 1); send(P, 2); send(ADD, 0);
        chk(tok_ready == 1'b0, "R7", "ready in execute cycle", tok_ready, 0);
        @(negedge clk);
        chk(tok_ready == 1'b1, "R7", "ready after execute", tok_ready, 1);
        send(FIN, 0);
        expect_res("R7", 3);

        // R2: unused kinds have no effect
        send(P, 5); send(6, 9); send(7, 9); send(FIN, 0);
        expect_res("R2", 5);

        // R6: malformed end with two entries
        send(P, 1); send(P, 2); send(FIN, 0);
        expect_err("R6", 4);

        // R9: overflow at DEPTH entries, then drain
        for (int i = 0; i <= DEPTH; i++) send(P, i);
        send(P, 1); send(FIN, 0);
        expect_err("R9", 1);

        // R10: underflow
        send(P, 4); send(ADD, 0); send(P, 8); send(FIN, 0);
        expect_err("R10", 2);

        // R11: divide by zero discards the rest, then recovery
        send(P, 4); send(P, 0); send(DIV, 0); send(P, 9); send(ADD, 0); send(FIN, 0);
        expect_err("R11", 3);
        send(P, 2); send(FIN, 0);
        expect_res("R11", 2);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule